// File: doc/BRIEF.md
# Board interrupt collector with card-socket status registers

This block sits on a simple byte-addressed register bus inside a board-control device. It gathers sixteen level-sensitive interrupt lines into a sticky pending register, qualifies them with an enable mask, and drives one combined interrupt output toward the host. Software clears or forces pending bits by writing the pending register. Bits 8 and 12 of the pending register cannot be set by a write. They can still be set by their input lines.

The block also holds two card-socket status/control registers. The low five bits of each are the power and reset controls, and software owns them. Bit 5 is an active-low card-present flag. It follows one dedicated interrupt line per socket: line 9 for socket 0 and line 13 for socket 1. This tracking runs on every clock, whether or not the bus is active. Bit 10 is a ready flag that is always set. Software cannot change any bit above bit 4.

Reads are combinational from the registers. Each value is zero-extended to the bus width. Writes take effect on the rising clock edge while the write strobe is high. Addresses are compared as whole bytes, so an unaligned address counts as unmapped.

Top module: `brdIrqRegs`

## Requirements
- R1: After reset, the mask reads 0 and the pending register reads 0. Both socket registers read 0x420 (ready bit 10 and card-detect bit 5 set). The interrupt output is 0.
- R2: The mask register at offset 0xC0 stores the written data in bits [19:0]. Bits above 19 read as 0.
- R3: Each input i (0..15) sets pending bit i at the next clock edge while the input is high and mask bit i is 1. An input whose mask bit is 0 sets nothing. A pending bit stays set after its input falls.
- R4: A write to the pending register at offset 0xC4 stores the written data ANDed with 0xFEEFF, so written bits 8 and 12 land as 0. In the same cycle, hardware sets from qualified inputs are ORed on top of the written value.
- R5: The interrupt output is 1 exactly when some bit is set in both the pending register and the mask. Clearing a mask bit hides that bit's pending state from the output but does not clear it.
- R6: Socket 0 sits at offset 0xE0 and socket 1 at 0xE4. A write to either replaces only bits [4:0]. Bits [9:6] read as 0.
- R7: Bit 5 of socket 0 becomes the inverse of input line 9 at each clock edge. Bit 5 of socket 1 does the same for line 13. A socket write in the same cycle leaves this tracking unaffected.
- R8: Bit 10 of both socket registers reads 1 at all times.
- R9: A read of any other offset returns 0. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the current address |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irqIn | input | 16 | Level interrupt inputs |
| irqOut | output | 1 | Combined interrupt toward the host |

## Verification
Two pairs of events can land in the same clock edge. The first pair is a software write to the pending register and a hardware set from a high, enabled line. The bench holds line 8 high with its mask bit set while it writes zero to the pending register, and it expects bit 8 to remain set. The second pair is a socket control write and a card-detect change. The bench flips line 13 on the same edge as a write to socket 1, and it expects both the new control bits and the cleared detect bit to appear in the next read.

// File: rtl/brdIrqPkg.sv
package brdIrqPkg;

  localparam int NUM_SOCK = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_PEND,
    SEL_SOCK0,
    SEL_SOCK1
  } rdSel_e;

  typedef struct packed {
    logic                wrMask;
    logic                wrPend;
    logic [NUM_SOCK-1:0] wrSock;
    rdSel_e              rdSel;
  } regStrobe_t;

endpackage

// File: rtl/brdIrqCtrl.sv
module brdIrqCtrl
  import brdIrqPkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 'hC0,
  parameter logic [ADDR_W-1:0] PEND_OFS  = 'hC4,
  parameter logic [ADDR_W-1:0] SOCK0_OFS = 'hE0,
  parameter logic [ADDR_W-1:0] SOCK1_OFS = 'hE4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb
);

  rdSel_e sel;

  // full-byte compare: anything off these four offsets is unmapped
  always_comb begin
    if (addr == MASK_OFS)       sel = SEL_MASK;
    else if (addr == PEND_OFS)  sel = SEL_PEND;
    else if (addr == SOCK0_OFS) sel = SEL_SOCK0;
    else if (addr == SOCK1_OFS) sel = SEL_SOCK1;
    else                        sel = SEL_NONE;
  end

  always_comb begin
    strb.rdSel     = sel;
    strb.wrMask    = wrEn && (sel == SEL_MASK);
    strb.wrPend    = wrEn && (sel == SEL_PEND);
    strb.wrSock[0] = wrEn && (sel == SEL_SOCK0);
    strb.wrSock[1] = wrEn && (sel == SEL_SOCK1);
  end

endmodule

// File: rtl/brdIrqDatapath.sv
module brdIrqDatapath
  import brdIrqPkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                NUM_IRQ    = 16,
  parameter int                PEND_W     = 20,
  parameter int                SOCK_W     = 11,
  parameter int                CTL_W      = 5,
  parameter int                CD_BIT     = 5,
  parameter int                RDY_BIT    = 10,
  parameter int                CD0_LINE   = 9,
  parameter int                CD1_LINE   = 13,
  parameter logic [PEND_W-1:0] PEND_WMASK = 'hFEEFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [PEND_W-1:0]  wrVal,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic [DATA_W-1:0]  rdata,
  output logic               irqOut,
  output logic [PEND_W-1:0]  maskQ,
  output logic [PEND_W-1:0]  pendQ,
  output logic [SOCK_W-1:0]  sock0Q,
  output logic [SOCK_W-1:0]  sock1Q
);

  localparam logic [SOCK_W-1:0] SOCK_RST =
    SOCK_W'((1 << RDY_BIT) | (1 << CD_BIT));

  logic [PEND_W-1:0] hwSet;
  logic [PEND_W-1:0] pendNxt;
  logic [SOCK_W-1:0] sockQ [NUM_SOCK];

  // mask register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.wrMask) maskQ <= wrVal;
  end

  // pending: the software value (or the held value), then the hardware sets ORed on top
  always_comb begin
    hwSet   = PEND_W'(irqIn) & maskQ;
    pendNxt = (strb.wrPend ? (wrVal & PEND_WMASK) : pendQ) | hwSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendNxt;
  end

  assign irqOut = |(pendQ & maskQ);

  // socket status/control registers, one per socket
  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    localparam int CD_LINE = (s == 0) ? CD0_LINE : CD1_LINE;
    logic [SOCK_W-1:0] sockNxt;

    always_comb begin
      sockNxt = sockQ[s];
      if (strb.wrSock[s]) sockNxt[CTL_W-1:0] = wrVal[CTL_W-1:0];
      sockNxt[CD_BIT] = ~irqIn[CD_LINE];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sockQ[s] <= SOCK_RST;
      else       sockQ[s] <= sockNxt;
    end
  end

  assign sock0Q = sockQ[0];
  assign sock1Q = sockQ[1];

  // read mux
  always_comb begin
    case (strb.rdSel)
      SEL_MASK:  rdata = DATA_W'(maskQ);
      SEL_PEND:  rdata = DATA_W'(pendQ);
      SEL_SOCK0: rdata = DATA_W'(sockQ[0]);
      SEL_SOCK1: rdata = DATA_W'(sockQ[1]);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/brdIrqRegs.sv
module brdIrqRegs
  import brdIrqPkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_IRQ = 16,
  parameter int PEND_W  = 20,
  parameter int SOCK_W  = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic               irqOut
);

  regStrobe_t        strb;
  logic [PEND_W-1:0] maskQ;
  logic [PEND_W-1:0] pendQ;
  logic [SOCK_W-1:0] sock0Q;
  logic [SOCK_W-1:0] sock1Q;
  logic              unusedWdataHi;

  assign unusedWdataHi = ^wdata[DATA_W-1:PEND_W];

  brdIrqCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  brdIrqDatapath #(
    .DATA_W  (DATA_W),
    .NUM_IRQ (NUM_IRQ),
    .PEND_W  (PEND_W),
    .SOCK_W  (SOCK_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrVal  (wdata[PEND_W-1:0]),
    .irqIn  (irqIn),
    .rdata  (rdata),
    .irqOut (irqOut),
    .maskQ  (maskQ),
    .pendQ  (pendQ),
    .sock0Q (sock0Q),
    .sock1Q (sock1Q)
  );

endmodule

// File: rtl/brdIrqChk.sv
module brdIrqChk #(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter int                NUM_IRQ    = 16,
  parameter int                PEND_W     = 20,
  parameter int                SOCK_W     = 11,
  parameter int                CTL_W      = 5,
  parameter int                CD_BIT     = 5,
  parameter int                RDY_BIT    = 10,
  parameter int                CD0_LINE   = 9,
  parameter int                CD1_LINE   = 13,
  parameter logic [PEND_W-1:0] PEND_WMASK = 'hFEEFF
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  rdata,
  input logic [NUM_IRQ-1:0] irqIn,
  input logic               irqOut,
  input logic [PEND_W-1:0]  maskQ,
  input logic [PEND_W-1:0]  pendQ,
  input logic [SOCK_W-1:0]  sock0Q,
  input logic [SOCK_W-1:0]  sock1Q
);

  logic mapped;
  assign mapped = (addr == ADDR_W'('hC0)) || (addr == ADDR_W'('hC4)) ||
                  (addr == ADDR_W'('hE0)) || (addr == ADDR_W'('hE4));

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ[NUM_IRQ-1:0] & $past(irqIn & maskQ[NUM_IRQ-1:0]))
              == $past(irqIn & maskQ[NUM_IRQ-1:0])));

  // R4
  pend_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~PEND_WMASK & ~PEND_W'($past(irqIn))) == '0));

  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((pendQ & maskQ) != '0));

  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(wrEn) || ($past(irqIn & maskQ[NUM_IRQ-1:0]) != '0)));

  // R6
  sock0_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_W'('hE0)) |=> $stable(sock0Q[CTL_W-1:0]));

  // R6
  sock1_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_W'('hE4)) |=> $stable(sock1Q[CTL_W-1:0]));

  // R6
  sock_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sock0Q[RDY_BIT-1:CD_BIT+1] == '0) && (sock1Q[RDY_BIT-1:CD_BIT+1] == '0));

  // R7
  sock0_cd_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (sock0Q[CD_BIT] == !$past(irqIn[CD0_LINE])));

  // R7
  sock1_cd_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (sock1Q[CD_BIT] == !$past(irqIn[CD1_LINE])));

  // R8
  sock_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    sock0Q[RDY_BIT] && sock1Q[RDY_BIT]);

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (rdata == '0));

endmodule

bind brdIrqRegs brdIrqChk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NUM_IRQ (NUM_IRQ),
  .PEND_W  (PEND_W),
  .SOCK_W  (SOCK_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .rdata  (rdata),
  .irqIn  (irqIn),
  .irqOut (irqOut),
  .maskQ  (maskQ),
  .pendQ  (pendQ),
  .sock0Q (sock0Q),
  .sock1Q (sock1Q)
);

// File: tb/sim_brdIrqRegs.sv
`timescale 1ns/1ps
module sim_brdIrqRegs;

  localparam logic [7:0] OFS_MASK = 8'hC0;
  localparam logic [7:0] OFS_PEND = 8'hC4;
  localparam logic [7:0] OFS_S0   = 8'hE0;
  localparam logic [7:0] OFS_S1   = 8'hE4;
  localparam int         WD_CYC   = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irqIn = '0;
  logic        irqOut;

  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  brdIrqRegs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  function automatic logic [31:0] sockExp(input logic [4:0] ctl, input logic cardIn);
    return 32'h400 | {27'd0, ctl} | (cardIn ? 32'h0 : 32'h20);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R1 watchdog got=running exp=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRd(OFS_MASK, d); chk("R1 mask", d, 32'h0);
    busRd(OFS_PEND, d); chk("R1 pend", d, 32'h0);
    busRd(OFS_S0, d);   chk("R1 sock0", d, 32'h420);
    busRd(OFS_S1, d);   chk("R1 sock1", d, 32'h420);
    chk("R1 irqOut", {31'd0, irqOut}, 32'h0);

    // R2 mask walking ones plus full patterns
    for (int b = 0; b < 32; b++) begin
      busWr(OFS_MASK, 32'h1 << b);
      busRd(OFS_MASK, d);
      chk("R2 mask walk", d, (32'h1 << b) & 32'hFFFFF);
    end
    busWr(OFS_MASK, 32'hA5A5A5A5);
    busRd(OFS_MASK, d); chk("R2 mask pattern", d, 32'hA5A5A5A5 & 32'hFFFFF);

    // R4 pending write masking, no inputs active
    busWr(OFS_MASK, 32'h0);
    for (int b = 0; b < 24; b++) begin
      busWr(OFS_PEND, 32'h1 << b);
      busRd(OFS_PEND, d);
      chk("R4 pend walk", d, (32'h1 << b) & 32'hFEEFF);
    end
    busWr(OFS_PEND, 32'hFFFFFFFF);
    busRd(OFS_PEND, d); chk("R4 pend all ones", d, 32'hFEEFF);
    // R5 pending alone with zero mask leaves the output low
    chk("R5 zero mask output", {31'd0, irqOut}, 32'h0);
    busWr(OFS_PEND, 32'h0);

    // R3 / R5 sweep over each line with every line driven high
    for (int i = 0; i < 16; i++) begin
      busWr(OFS_MASK, 32'h1 << i);
      @(negedge clk); irqIn = 16'hFFFF;
      busRd(OFS_PEND, d); chk("R3 only enabled line sets", d, 32'h1 << i);
      chk("R5 output raised", {31'd0, irqOut}, 32'h1);
      @(negedge clk); irqIn = 16'h0;
      busRd(OFS_PEND, d); chk("R3 sticky after fall", d, 32'h1 << i);
      busWr(OFS_MASK, 32'h0);
      busRd(OFS_PEND, d); chk("R5 pend kept when masked", d, 32'h1 << i);
      chk("R5 output hidden", {31'd0, irqOut}, 32'h0);
      busWr(OFS_PEND, 32'h0);
    end

    // R4 same-cycle write of zero while line 8 is high and enabled
    busWr(OFS_MASK, 32'h100);
    @(negedge clk); irqIn = 16'h0100;
    busWr(OFS_PEND, 32'h0);
    busRd(OFS_PEND, d); chk("R4 hw set beats clear", d, 32'h100);
    @(negedge clk); irqIn = 16'h0;
    busWr(OFS_PEND, 32'h0);
    busRd(OFS_PEND, d); chk("R4 clear after fall", d, 32'h0);
    busWr(OFS_MASK, 32'h0);

    // R6 socket control writes
    busWr(OFS_S0, 32'hFFFFFFFF);
    busRd(OFS_S0, d); chk("R6 sock0 ones", d, sockExp(5'h1F, 1'b0));
    busRd(OFS_S1, d); chk("R6 sock1 untouched", d, sockExp(5'h00, 1'b0));
    busWr(OFS_S1, 32'hFFFFFBCA);
    busRd(OFS_S1, d); chk("R6 sock1 pattern", d, sockExp(5'h0A, 1'b0));
    busWr(OFS_S0, 32'h0);
    busRd(OFS_S0, d); chk("R6 sock0 zero", d, sockExp(5'h00, 1'b0));

    // R7 / R8 card detect sweep over both lines
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      irqIn = 16'h0; irqIn[9] = p[0]; irqIn[13] = p[1];
      busRd(OFS_S0, d); chk("R7 sock0 detect", d, sockExp(5'h00, p[0]));
      busRd(OFS_S1, d); chk("R7 sock1 detect", d, sockExp(5'h0A, p[1]));
      chk("R8 ready", d & 32'h400, 32'h400);
    end

    // R7 same-cycle socket write and detect change
    @(negedge clk); irqIn = 16'h0;
    @(negedge clk);
    wrEn = 1'b1; addr = OFS_S1; wdata = 32'h1F; irqIn[13] = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    busRd(OFS_S1, d); chk("R7 write with detect", d, sockExp(5'h1F, 1'b1));
    @(negedge clk); irqIn = 16'h0;

    // R9 unmapped reads and writes
    busWr(OFS_MASK, 32'h3);
    busWr(OFS_PEND, 32'h1);
    for (int a = 0; a < 256; a += 4) begin
      if (a != 'hC0 && a != 'hC4 && a != 'hE0 && a != 'hE4) begin
        busRd(8'(a), d); chk("R9 unmapped read", d, 32'h0);
      end
    end
    busRd(8'hE1, d); chk("R9 unaligned read", d, 32'h0);
    busWr(8'h10, 32'hFFFFFFFF);
    busWr(8'hE8, 32'hFFFFFFFF);
    busWr(8'hC1, 32'hFFFFFFFF);
    busRd(OFS_MASK, d); chk("R9 mask kept", d, 32'h3);
    busRd(OFS_PEND, d); chk("R9 pend kept", d, 32'h1);
    busRd(OFS_S0, d);   chk("R9 sock0 kept", d, sockExp(5'h00, 1'b0));
    busRd(OFS_S1, d);   chk("R9 sock1 kept", d, sockExp(5'h1F, 1'b0));
    chk("R5 output with pend and mask", {31'd0, irqOut}, 32'h1);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule